// File: doc/BRIEF.md
# Accumulator Store Saturation Unit

This unit sits on the path that carries a value out of one of two 40-bit accumulators to memory or to another register. Each accumulator holds a signed 32-bit value with 8 guard bits above it. When a store is requested, the unit picks the accumulator and the part of it that is wanted. If saturation is enabled for that accumulator and the value lies outside the signed 32-bit range, the unit passes on a clamped value in place of the raw one.

Clamping acts only on the data that leaves the unit. The accumulator inputs are never written back. It applies to every part of the accumulator that can be read: the full 32-bit word, either 16-bit half, or the guard byte. Each accumulator has its own active-high disable bit, and both bits are expected to reset to 0, so saturation is on after reset. A one-cycle flag goes high with each stored value that was clamped.

Top module: `acc_store_sat`

## Requirements
- R1: During reset and at the first clock after it, `st_data` is 0 and `st_ovf` is 0.
- R2: `st_data` and `st_ovf` are registered. They show the result of a store one clock after the edge that samples `st_en`=1. While `st_en` is 0, `st_data` holds its value and `st_ovf` is 0.
- R3: `acc_sel`=0 stores from `acc0` and `acc_sel`=1 stores from `acc1`. The accumulator that is not selected has no effect on the result.
- R4: A value overflows when bits [39:32] are not all equal to bit 31, which means it lies outside [-2^31, 2^31-1].
- R5: `sat_off[0]` disables clamping for `acc0` and `sat_off[1]` disables it for `acc1`. A 0 enables clamping and a 1 disables it. A disabled accumulator is passed through unchanged even when it overflows.
- R6: The clamped 40-bit value is 0x007FFFFFFF when bit 39 is 0 and 0xFF80000000 when bit 39 is 1.
- R7: `part`=00 stores bits [31:0] of the value, clamped where R4 to R6 apply.
- R8: `part`=01 stores bits [31:16] of the value in `st_data[15:0]`, and the upper bits of `st_data` are 0.
- R9: `part`=10 stores bits [15:0] of the value in `st_data[15:0]`, and the upper bits of `st_data` are 0.
- R10: `part`=11 stores the guard byte, bits [39:32] of the value, zero-extended. A clamped value gives 0x00 or 0xFF here.
- R11: `st_ovf` is 1 for exactly the one cycle in which a clamped store is presented, whatever the part, and is 0 for every other store.
- R12: Clamping leaves no state behind. A later store of the same accumulator with clamping disabled returns the raw bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc0 | input | 40 | Accumulator 0 contents |
| acc1 | input | 40 | Accumulator 1 contents |
| st_en | input | 1 | Store request |
| acc_sel | input | 1 | Accumulator select |
| part | input | 2 | Portion select (00 full, 01 high, 10 low, 11 guard) |
| sat_off | input | 2 | Per-accumulator clamping disable, bit i for accumulator i |
| st_data | output | 32 | Data to be stored |
| st_ovf | output | 1 | Clamp-occurred pulse |

## Verification
Any internal fault in this unit reaches the ports one clock after the store that triggers it. A wrong overflow test, a swapped disable bit or a bad clamp constant corrupts `st_data` and `st_ovf` on that store and on no later one. A sticky clamp or flag would show up on the following store as an unexpected limit value or a second pulse. The sweep therefore checks every store on the next cycle, and it also checks an idle cycle after each store for hold and flag clearing.

// File: rtl/acc_store_sat.sv
module acc_store_sat #(
  parameter int ACC_W  = 40,
  parameter int WORD_W = 32,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ACC_W-1:0]  acc0,
  input  logic [ACC_W-1:0]  acc1,
  input  logic              st_en,
  input  logic              acc_sel,
  input  logic [1:0]        part,
  input  logic [1:0]        sat_off,
  output logic [WORD_W-1:0] st_data,
  output logic              st_ovf
);
  localparam int GRD_W = ACC_W - WORD_W;
  localparam int TOP_W = GRD_W + 1;

  logic [ACC_W-1:0]  src, lim, val;
  logic [TOP_W-1:0]  top;
  logic              ovr, clamp, neg;
  logic [WORD_W-1:0] pick;

  assign src   = acc_sel ? acc1 : acc0;
  assign top   = src[ACC_W-1:WORD_W-1];
  assign ovr   = ~(&top) & (|top);
  assign clamp = ovr & ~sat_off[acc_sel];
  assign neg   = src[ACC_W-1];
  assign lim   = {{TOP_W{neg}}, {(WORD_W-1){~neg}}};
  assign val   = clamp ? lim : src;

  always_comb begin
    case (part)
      2'b00:   pick = val[WORD_W-1:0];
      2'b01:   pick = {{(WORD_W-HALF_W){1'b0}}, val[WORD_W-1:WORD_W-HALF_W]};
      2'b10:   pick = {{(WORD_W-HALF_W){1'b0}}, val[HALF_W-1:0]};
      default: pick = {{(WORD_W-GRD_W){1'b0}}, val[ACC_W-1:WORD_W]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_data <= '0;
      st_ovf  <= 1'b0;
    end else begin
      st_ovf <= st_en & clamp;
      if (st_en) st_data <= pick;
    end
  end
endmodule

module acc_store_sat_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_en,
  input logic              acc_sel,
  input logic [1:0]        part,
  input logic [1:0]        sat_off,
  input logic [WORD_W-1:0] st_data,
  input logic              st_ovf
);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !st_en |=> ($stable(st_data) && !st_ovf));

  // R11
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_ovf |-> $past(st_en));

  // R5
  disabled_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_en && sat_off[acc_sel]) |=> !st_ovf);

  // R6
  full_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_en && part == 2'b00) |=> (st_ovf -> ((st_data[WORD_W-1] != st_data[WORD_W-2]) &&
      ((&st_data[WORD_W-2:0]) || !(|st_data[WORD_W-2:0])))));

  // R10
  guard_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_en && part == 2'b11) |=> (st_ovf -> (st_data == 'h0 || st_data == 'hFF)));

  // R8
  half_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_en && part != 2'b00) |=> (st_data[WORD_W-1:16] == '0));
endmodule

bind acc_store_sat acc_store_sat_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_en(st_en), .acc_sel(acc_sel), .part(part),
  .sat_off(sat_off), .st_data(st_data), .st_ovf(st_ovf)
);

// File: tb/tb_acc_store_sat.sv
`timescale 1ns/1ps
module tb_acc_store_sat;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [39:0] acc0 = '0, acc1 = '0;
  logic        st_en = 1'b0, acc_sel = 1'b0;
  logic [1:0]  part = 2'b00, sat_off = 2'b00;
  logic [31:0] st_data;
  logic        st_ovf;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  acc_store_sat dut (.clk(clk), .rst_n(rst_n), .acc0(acc0), .acc1(acc1), .st_en(st_en),
    .acc_sel(acc_sel), .part(part), .sat_off(sat_off), .st_data(st_data), .st_ovf(st_ovf));

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic logic [32:0] expect_store(logic [39:0] raw, bit enabled, logic [1:0] p);
    longint s;
    logic [39:0] v;
    bit o;
    s = longint'($signed(raw));
    o = enabled && (s > 64'sd2147483647 || s < -64'sd2147483648);
    if (o) s = (s > 0) ? 64'sd2147483647 : -64'sd2147483648;
    v = s[39:0];
    case (p)
      2'b00: return {o, v[31:0]};
      2'b01: return {o, 16'h0, v[31:16]};
      2'b10: return {o, 16'h0, v[15:0]};
      default: return {o, 24'h0, v[39:32]};
    endcase
  endfunction

  task automatic store(logic [39:0] a0, logic [39:0] a1, bit sel, logic [1:0] p, logic [1:0] off);
    logic [32:0] e;
    logic [31:0] held;
    e = expect_store(sel ? a1 : a0, !off[sel], p);
    @(negedge clk);
    acc0 = a0; acc1 = a1; acc_sel = sel; part = p; sat_off = off; st_en = 1'b1;
    @(negedge clk);
    st_en = 1'b0;
    chk(p == 2'b00 ? "R7" : p == 2'b01 ? "R8" : p == 2'b10 ? "R9" : "R10", st_data, e[31:0]);
    chk("R11", {31'h0, st_ovf}, {31'h0, e[32]});
    held = st_data;
    acc0 = ~a0; acc1 = ~a1; part = ~p;
    @(negedge clk);
    chk("R2", st_data, held);
    chk("R11", {31'h0, st_ovf}, 32'h0);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    done = 1;
  end

  initial begin
    logic [7:0] gs [6];
    logic [39:0] v;
    gs = '{8'h00, 8'hFF, 8'h01, 8'h7F, 8'h80, 8'hFE};
    repeat (3) @(negedge clk);
    chk("R1", st_data, 32'h0);
    chk("R1", {31'h0, st_ovf}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", st_data, 32'h0);
    for (int g = 0; g < 6; g++)
      for (int b = 0; b < 2; b++) begin
        v = {gs[g], b[0], 31'h0} | {9'h0, 31'(32'h1234567 * (g * 2 + b + 1))};
        for (int sel = 0; sel < 2; sel++)
          for (int p = 0; p < 4; p++)
            for (int off = 0; off < 4; off++) begin
              // R3 R4 R5 R6: the other accumulator carries a distinct value
              if (sel == 0) store(v, {~v[39:32], v[31:0] ^ 32'hA5A5A5A5}, 1'b0, 2'(p), 2'(off));
              else          store({~v[39:32], v[31:0] ^ 32'h5A5A5A5A}, v, 1'b1, 2'(p), 2'(off));
            end
      end
    // R6 exact limits, R4 boundaries
    store(40'h00_7FFFFFFF, 40'h0, 1'b0, 2'b00, 2'b00);
    chk("R4", {31'h0, st_ovf}, 32'h0);
    store(40'h00_80000000, 40'h0, 1'b0, 2'b00, 2'b00);
    chk("R6", st_data, 32'h7FFFFFFF);
    store(40'h0, 40'hFF_7FFFFFFF, 1'b1, 2'b00, 2'b00);
    chk("R6", st_data, 32'h80000000);
    store(40'h0, 40'hFF_80000000, 1'b1, 2'b00, 2'b00);
    chk("R4", st_data, 32'h80000000);
    // R12 clamp does not persist
    store(40'h12_3456789A, 40'h0, 1'b0, 2'b11, 2'b00);
    chk("R12", st_data, 32'h00);
    store(40'h12_3456789A, 40'h0, 1'b0, 2'b11, 2'b01);
    chk("R12", st_data, 32'h12);
    store(40'h12_3456789A, 40'h0, 1'b0, 2'b00, 2'b10);
    chk("R12", st_data, 32'h7FFFFFFF);
    if (!done) begin
      done = 1;
    end
  end

  initial begin
    wait (done);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule